// File: doc/BRIEF.md
# BCD Time-of-Day Counter with Manual Setting

This block keeps the time of day in a 24-hour format as three packed BCD bytes: hours, minutes and seconds. Each byte holds the tens digit in bits [7:4] and the units digit in bits [3:0], so the byte 0x15 reads as fifteen. Arithmetic is done directly on the digits, and no binary value is ever formed. A single-cycle 1 Hz enable from outside advances the seconds. Carries ripple from seconds into minutes and from minutes into hours. A leap-second request makes the seconds byte show 0x59 for one extra tick.

Two push buttons set the time. Each button passes through a synchronizer and a debouncer. The debouncer samples on an external 100 Hz strobe and accepts a new level only after five agreeing samples in a row. The mode button steps through run, set-minutes and set-hours. The increment button adds one to the field that the current mode selects. A synchronous clear zeroes every field at once. Generating the oscillator, dividing it down and driving the display are left to other logic.

Top module: `tod_clock`

## Requirements
- R1: Each output digit is a 4-bit BCD value from 0 to 9. Hours tens never exceeds 2 and minutes or seconds tens never exceeds 5. The hour byte is {hr_tens, hr_units}, and the minute and second bytes are formed the same way.
- R2: In run mode, each cycle with `tick_1hz` high adds one to seconds. A units digit of 9 becomes 0 and carries into the tens digit. Seconds wrap from 0x59 to 0x00 and add one to minutes on the same edge.
- R3: On a seconds carry, minutes wrap from 0x59 to 0x00 and carry into hours. Hours wrap from 0x23 to 0x00, so a full day of 86400 ticks returns to 00:00:00.
- R4: A `leap_req` pulse arms a pending leap second. The next run-mode tick that finds seconds at 0x59 leaves them at 0x59 and consumes the request. The following tick wraps to 0x00 with the normal carry. Later minutes roll over without a hold.
- R5: `mode` is 0 for run, 1 for set-minutes and 2 for set-hours. Each rising edge of the debounced mode button advances the mode 0→1→2→0.
- R6: A button level is accepted only after five consecutive `sample_100hz` strobes see the new level. A press that lasts fewer strobes has no effect.
- R7: In set-minutes mode, each debounced press of the increment button adds one to minutes. Minutes wrap from 0x59 to 0x00 and hours stay unchanged.
- R8: In set-hours mode, each debounced press of the increment button adds one to hours. Hours wrap from 0x23 to 0x00 and minutes stay unchanged.
- R9: While either set mode is active, `tick_1hz` is ignored and seconds are held at 0x00.
- R10: `rst` or `clr` zeroes hours, minutes and seconds, returns the mode to run and drops any pending leap second.
- R11: In run mode, a press of the increment button leaves the time unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of all fields and of the mode |
| tick_1hz | input | 1 | Single-cycle 1 Hz advance enable |
| sample_100hz | input | 1 | Single-cycle button sample strobe |
| leap_req | input | 1 | Arms a leap second |
| btn_mode | input | 1 | Raw mode button |
| btn_inc | input | 1 | Raw increment button |
| hr_tens | output | 4 | Hours tens digit |
| hr_units | output | 4 | Hours units digit |
| min_tens | output | 4 | Minutes tens digit |
| min_units | output | 4 | Minutes units digit |
| sec_tens | output | 4 | Seconds tens digit |
| sec_units | output | 4 | Seconds units digit |
| mode | output | 2 | Current mode (0 run, 1 set minutes, 2 set hours) |

## Verification
The assertions check properties that must hold on every cycle:
- Every digit stays a legal BCD value.
- Each field wraps from its maximum to zero.
- The leap hold keeps seconds at 0x59.
- Seconds stay at zero in a set mode.
- The mode steps in the correct order.
- A debounced level changes only on a sample strobe.

Some behaviour only the bench scenarios can show:
- A full-day sweep compares every tick against arithmetic expectations.
- Glitches shorter than five samples are rejected.
- The increment button is ignored in run mode.
- The leap second is consumed exactly once.
- Set-mode presses sweep minutes and hours through their wraps.

// File: rtl/tod_pkg.sv
package tod_pkg;
  typedef enum logic [1:0] {
    MODE_RUN     = 2'd0,
    MODE_SET_MIN = 2'd1,
    MODE_SET_HR  = 2'd2
  } tod_mode_t;

  localparam logic [7:0] SEC_LAST = 8'h59;
  localparam logic [7:0] MIN_LAST = 8'h59;
  localparam logic [7:0] HR_LAST  = 8'h23;
  localparam int         NUM_BTN  = 2;
  localparam int         BTN_MODE = 0;
  localparam int         BTN_INC  = 1;
endpackage

// File: rtl/tod_debounce.sv
module tod_debounce #(
  parameter int STABLE_SAMPLES = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic sample_en,
  input  logic btn_raw,
  output logic rise
);
  localparam int CW = $clog2(STABLE_SAMPLES + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] agree_cnt;
  logic          level_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q    <= '0;
      agree_cnt <= '0;
      level_q   <= 1'b0;
      rise      <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], btn_raw};
      rise   <= 1'b0;
      if (sample_en) begin
        if (sync_q[1] != level_q) begin
          if (agree_cnt == CW'(STABLE_SAMPLES - 1)) begin
            level_q   <= sync_q[1];
            agree_cnt <= '0;
            rise      <= sync_q[1];
          end else begin
            agree_cnt <= agree_cnt + 1'b1;
          end
        end else begin
          agree_cnt <= '0;
        end
      end
    end
  end

  // R6
  level_only_on_sample_chk: assert property (@(posedge clk) disable iff (rst)
    (!sample_en && !rst) |=> $stable(level_q));

  // R6
  rise_means_high_chk: assert property (@(posedge clk) disable iff (rst)
    rise |-> level_q);
endmodule

// File: rtl/tod_bcd_field.sv
module tod_bcd_field #(
  parameter logic [7:0] LAST = 8'h59
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       zero,
  input  logic       inc,
  output logic [7:0] value,
  output logic       at_last
);
  localparam logic [3:0] TENS_MAX = LAST[7:4];

  assign at_last = (value == LAST);

  always_ff @(posedge clk) begin
    if (rst || zero) begin
      value <= '0;
    end else if (inc) begin
      if (value == LAST) begin
        value <= '0;
      end else if (value[3:0] == 4'd9) begin
        value <= {value[7:4] + 4'd1, 4'd0};
      end else begin
        value[3:0] <= value[3:0] + 4'd1;
      end
    end
  end

  // R1
  digit_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (value[3:0] <= 4'd9) && (value[7:4] <= TENS_MAX));

  // R3
  field_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !zero && !rst && value == LAST) |=> (value == 8'h00));

  // R2
  field_moves_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !zero && !rst) |=> (value != $past(value)));
endmodule

// File: rtl/tod_mode_ctl.sv
module tod_mode_ctl
  import tod_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      clr,
  input  logic      step,
  output tod_mode_t mode_q
);
  tod_mode_t mode_d;

  always_comb begin
    mode_d = mode_q;
    if (step) begin
      unique case (mode_q)
        MODE_RUN:     mode_d = MODE_SET_MIN;
        MODE_SET_MIN: mode_d = MODE_SET_HR;
        default:      mode_d = MODE_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) mode_q <= MODE_RUN;
    else            mode_q <= mode_d;
  end

  // R5
  mode_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !clr && !rst && mode_q == MODE_SET_HR) |=> (mode_q == MODE_RUN));

  // R5
  mode_enter_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !clr && !rst && mode_q == MODE_RUN) |=> (mode_q == MODE_SET_MIN));

  // R5
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!step && !clr && !rst) |=> $stable(mode_q));
endmodule

// File: rtl/tod_clock.sv
module tod_clock
  import tod_pkg::*;
#(
  parameter int DEBOUNCE_SAMPLES = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       tick_1hz,
  input  logic       sample_100hz,
  input  logic       leap_req,
  input  logic       btn_mode,
  input  logic       btn_inc,
  output logic [3:0] hr_tens,
  output logic [3:0] hr_units,
  output logic [3:0] min_tens,
  output logic [3:0] min_units,
  output logic [3:0] sec_tens,
  output logic [3:0] sec_units,
  output logic [1:0] mode
);
  logic [NUM_BTN-1:0] btn_raw;
  logic [NUM_BTN-1:0] btn_rise;

  assign btn_raw[BTN_MODE] = btn_mode;
  assign btn_raw[BTN_INC]  = btn_inc;

  for (genvar b = 0; b < NUM_BTN; b++) begin : g_btn
    tod_debounce #(.STABLE_SAMPLES(DEBOUNCE_SAMPLES)) u_db (
      .clk       (clk),
      .rst       (rst),
      .sample_en (sample_100hz),
      .btn_raw   (btn_raw[b]),
      .rise      (btn_rise[b])
    );
  end

  tod_mode_t mode_q;

  tod_mode_ctl u_mode (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr),
    .step   (btn_rise[BTN_MODE]),
    .mode_q (mode_q)
  );

  logic [7:0] sec_q, min_q, hr_q;
  logic       sec_last, min_last, hr_last;
  logic       in_set, run_tick, leap_pend, leap_hold;
  logic       sec_inc, min_inc, hr_inc, sec_zero;

  assign in_set    = (mode_q != MODE_RUN);
  assign run_tick  = tick_1hz && !in_set;
  assign leap_hold = run_tick && sec_last && leap_pend;
  assign sec_inc   = run_tick && !leap_hold;
  assign sec_zero  = clr || in_set;

  always_comb begin
    unique case (mode_q)
      MODE_SET_MIN: begin
        min_inc = btn_rise[BTN_INC];
        hr_inc  = 1'b0;
      end
      MODE_SET_HR: begin
        min_inc = 1'b0;
        hr_inc  = btn_rise[BTN_INC];
      end
      default: begin
        min_inc = sec_inc && sec_last;
        hr_inc  = sec_inc && sec_last && min_last;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clr)     leap_pend <= 1'b0;
    else if (leap_req)  leap_pend <= 1'b1;
    else if (leap_hold) leap_pend <= 1'b0;
  end

  tod_bcd_field #(.LAST(SEC_LAST)) u_sec (
    .clk (clk), .rst (rst), .zero (sec_zero), .inc (sec_inc),
    .value (sec_q), .at_last (sec_last)
  );

  tod_bcd_field #(.LAST(MIN_LAST)) u_min (
    .clk (clk), .rst (rst), .zero (clr), .inc (min_inc),
    .value (min_q), .at_last (min_last)
  );

  tod_bcd_field #(.LAST(HR_LAST)) u_hr (
    .clk (clk), .rst (rst), .zero (clr), .inc (hr_inc),
    .value (hr_q), .at_last (hr_last)
  );

  assign hr_tens   = hr_q[7:4];
  assign hr_units  = hr_q[3:0];
  assign min_tens  = min_q[7:4];
  assign min_units = min_q[3:0];
  assign sec_tens  = sec_q[7:4];
  assign sec_units = sec_q[3:0];
  assign mode      = mode_q;

  // R4
  leap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (leap_hold && !clr && !rst) |=> (sec_q == SEC_LAST && !leap_pend));

  // R9
  set_sec_zero_chk: assert property (@(posedge clk) disable iff (rst)
    in_set |=> (sec_q == 8'h00));

  // R10
  clear_all_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (sec_q == 8'h00 && min_q == 8'h00 && hr_q == 8'h00 && mode_q == MODE_RUN));

  // R3
  day_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (hr_inc && hr_last && !clr && !rst) |=> (hr_q == 8'h00));
endmodule

// File: tb/tod_clock_tb.sv
`timescale 1ns/1ps
module tod_clock_tb;
  logic clk = 1'b0;
  logic rst = 1'b1, clr = 1'b0, tick = 1'b0, samp = 1'b0, leap = 1'b0;
  logic bmode = 1'b0, binc = 1'b0;
  logic [3:0] ht, hu, mt, mu, st, su;
  logic [1:0] mode;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tod_clock u_dut (
    .clk(clk), .rst(rst), .clr(clr), .tick_1hz(tick), .sample_100hz(samp),
    .leap_req(leap), .btn_mode(bmode), .btn_inc(binc),
    .hr_tens(ht), .hr_units(hu), .min_tens(mt), .min_units(mu),
    .sec_tens(st), .sec_units(su), .mode(mode)
  );

  function automatic logic [7:0] bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  task automatic chk_time(string req, int h, int m, int s);
    logic [23:0] act, exp;
    act = {ht, hu, mt, mu, st, su};
    exp = {bcd(h), bcd(m), bcd(s)};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s time act=%06h exp=%06h", req, act, exp);
    end
  endtask

  task automatic chk_mode(string req, int m);
    checks++;
    if (mode !== 2'(m)) begin
      errors++;
      $display("FAIL %s mode act=%0d exp=%0d", req, mode, m);
    end
  endtask

  task automatic ticks(int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic samples(int n);
    for (int i = 0; i < n; i++) begin
      samp = 1'b1; @(negedge clk);
      samp = 1'b0; @(negedge clk);
    end
  endtask

  // which: 0 mode button, 1 increment button; held for n strobes
  task automatic press(int which, int n);
    if (which == 0) bmode = 1'b1; else binc = 1'b1;
    repeat (3) @(negedge clk);
    samples(n);
    bmode = 1'b0; binc = 1'b0;
    repeat (3) @(negedge clk);
    samples(6);
    repeat (4) @(negedge clk);
  endtask

  task automatic do_clear();
    clr = 1'b1; @(negedge clk);
    clr = 1'b0; @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk_time("R10", 0, 0, 0);
    chk_mode("R10", 0);

    // R1 R2 R3 full-day sweep
    tick = 1'b1;
    for (int i = 1; i <= 86400; i++) begin
      @(negedge clk);
      chk_time("R2/R3", (i % 86400) / 3600, (i % 3600) / 60, i % 60);
    end
    tick = 1'b0;
    @(negedge clk);
    chk_time("R3", 0, 0, 0);

    // R4 leap second
    ticks(58);
    chk_time("R2", 0, 0, 58);
    leap = 1'b1; @(negedge clk); leap = 1'b0;
    ticks(1);
    chk_time("R4", 0, 0, 59);
    ticks(1);
    chk_time("R4", 0, 0, 59);
    ticks(1);
    chk_time("R4", 0, 1, 0);
    ticks(60);
    chk_time("R4", 0, 2, 0);
    ticks(5);
    chk_time("R2", 0, 2, 5);

    // R11 increment ignored in run mode
    press(1, 6);
    chk_time("R11", 0, 2, 5);
    chk_mode("R11", 0);

    // R6 short mode glitch rejected
    press(0, 3);
    chk_mode("R6", 0);
    chk_time("R6", 0, 2, 5);

    // R5 R9 set-minutes
    press(0, 6);
    chk_mode("R5", 1);
    chk_time("R9", 0, 2, 0);
    ticks(4);
    chk_time("R9", 0, 2, 0);

    // R7 sweep minutes through wrap
    for (int k = 1; k <= 58; k++) begin
      press(1, 5);
      chk_time("R7", 0, (2 + k) % 60, 0);
    end

    // R8 set-hours sweep through wrap
    press(0, 6);
    chk_mode("R5", 2);
    for (int k = 1; k <= 24; k++) begin
      press(1, 5);
      chk_time("R8", k % 24, 0, 0);
    end
    press(1, 5);
    press(1, 5);
    chk_time("R8", 2, 0, 0);

    // R5 back to run, ticking resumes
    press(0, 6);
    chk_mode("R5", 0);
    ticks(1);
    chk_time("R9", 2, 0, 1);

    // R10 clear from a set mode
    press(0, 6);
    chk_mode("R5", 1);
    do_clear();
    chk_time("R10", 0, 0, 0);
    chk_mode("R10", 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule